// File: doc/BRIEF.md
# Decimal Floating-Point Exponent Comparator

This combinational unit orders the biased exponents of two decimal floating-point operands. The operands use either the 64-bit or the 128-bit interchange format. For each operand the caller supplies the most significant 32-bit word of the encoding and a biased exponent that an upstream decoder has already extracted. One select input names the format, and it applies to both operands.

The result is a 4-bit condition code. It reports whether the exponent of operand A is lower than, higher than or equal to the exponent of operand B, or whether the two are unordered. The significands are never looked at.

Infinities and NaNs are recognised directly from the masked combination field of each upper word. A pair of specials of the same kind counts as equal. Any other pairing that involves a special counts as unordered, unless the two supplied exponents already match.

Top module: `dfp_exp_compare`

## Requirements
- R1: The combination field is the upper word ANDed with 0x7FFC0000 when `fmt_wide` is 0 (64-bit format) and with 0x7FFFC000 when `fmt_wide` is 1 (128-bit format). Bits outside that mask, the sign bit (bit 31) included, do not affect the result.
- R2: An operand is a NaN when its combination field equals exactly 0x7C000000 or 0x7E000000. It is an infinity when the field equals exactly 0x78000000. Every other field value is finite.
- R3: `cond[3]` (A below B) is 1 only when both operands are finite and the effective exponent of A is below that of B as unsigned numbers.
- R4: `cond[2]` (A above B) is 1 only when both operands are finite and the effective exponent of B is below that of A as unsigned numbers.
- R5: `cond[1]` (equal) is 1 when any one of these holds: the effective exponents are equal, both operands are infinities, or both operands are NaNs.
- R6: `cond[0]` (unordered) is 1 when at least one operand is an infinity or a NaN and the condition of R5 does not hold.
- R7: In the 64-bit format the effective exponent is bits [9:0] of the exponent input, zero-extended, and bits [13:10] are ignored. In the 128-bit format the effective exponent is all 14 bits.
- R8: Exactly one bit of `cond` is 1 for every input combination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_hi | input | 32 | Most significant word of operand A |
| op_b_hi | input | 32 | Most significant word of operand B |
| fmt_wide | input | 1 | 0 = 64-bit format, 1 = 128-bit format |
| exp_a | input | 14 | Biased exponent of operand A |
| exp_b | input | 14 | Biased exponent of operand B |
| cond | output | 4 | {below, above, equal, unordered} |

## Verification
Two functions can act on the same input: special-value detection and exponent equality. They meet when an infinity or a NaN is paired with a finite operand whose exponent is identical. The bench provokes this with directed vectors of that kind. It also forces equal exponents in a quarter of the random vectors, which are biased toward special and near-special upper words. It judges each result against a reference function written from R1 to R7: equality takes precedence, so such a pair must report equal and never unordered, and the code must stay one-hot.

// File: rtl/dfp_xcmp_pkg.sv
package dfp_xcmp_pkg;

    parameter int WORD_W     = 32;
    parameter int EXP_W_NARR = 10;
    parameter int EXP_W_WIDE = 14;

    localparam logic [WORD_W-1:0] FIELD_MASK_NARR = 32'h7FFC_0000;
    localparam logic [WORD_W-1:0] FIELD_MASK_WIDE = 32'h7FFF_C000;
    localparam logic [WORD_W-1:0] PAT_NAN_QUIET   = 32'h7C00_0000;
    localparam logic [WORD_W-1:0] PAT_NAN_SIGNAL  = 32'h7E00_0000;
    localparam logic [WORD_W-1:0] PAT_INFINITE    = 32'h7800_0000;

    typedef enum logic {
        FMT_NARR = 1'b0,
        FMT_WIDE = 1'b1
    } fmt_e;

    typedef struct packed {
        logic nan;
        logic inf;
    } kind_t;

    // Field order sets the bit position: lt is bit 3, un is bit 0.
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic un;
    } cond_t;

    function automatic logic [WORD_W-1:0] field_mask(fmt_e fmt);
        return (fmt == FMT_WIDE) ? FIELD_MASK_WIDE : FIELD_MASK_NARR;
    endfunction

    function automatic kind_t classify(logic [WORD_W-1:0] fld);
        kind_t k;
        k.nan = (fld == PAT_NAN_QUIET) || (fld == PAT_NAN_SIGNAL);
        k.inf = (fld == PAT_INFINITE);
        return k;
    endfunction

endpackage

// File: rtl/dfp_xcmp_kind.sv
module dfp_xcmp_kind
    import dfp_xcmp_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] word_hi,
    input  fmt_e         fmt,
    output kind_t        kind
);

    logic [W-1:0] comb_field;

    always_comb begin
        comb_field = word_hi & field_mask(fmt);
        kind       = classify(comb_field);
    end

    always_comb begin
        a_r2_kind_exclusive: assert (!(kind.nan && kind.inf))
            else $error("operand classified as NaN and infinity together");
        if (word_hi[W-1]) begin
            a_r1_sign_not_in_field: assert (comb_field[W-1] == 1'b0)
                else $error("sign bit leaked into combination field");
        end
    end

endmodule

// File: rtl/dfp_xcmp_exp.sv
module dfp_xcmp_exp
    import dfp_xcmp_pkg::*;
#(
    parameter int NARR_W = EXP_W_NARR,
    parameter int WIDE_W = EXP_W_WIDE
) (
    input  logic [WIDE_W-1:0] exp_in,
    input  fmt_e              fmt,
    output logic [WIDE_W-1:0] exp_eff
);

    localparam int PAD_W = WIDE_W - NARR_W;

    always_comb begin
        if (fmt == FMT_WIDE) begin
            exp_eff = exp_in;
        end else begin
            exp_eff = {{PAD_W{1'b0}}, exp_in[NARR_W-1:0]};
        end
    end

    always_comb begin
        if (fmt == FMT_NARR) begin
            a_r7_narrow_zero_ext: assert (exp_eff[WIDE_W-1:NARR_W] == '0)
                else $error("narrow exponent not zero-extended");
        end
    end

endmodule

// File: rtl/dfp_exp_compare.sv
module dfp_exp_compare
    import dfp_xcmp_pkg::*;
#(
    parameter int W      = WORD_W,
    parameter int NARR_W = EXP_W_NARR,
    parameter int WIDE_W = EXP_W_WIDE
) (
    input  logic [W-1:0]      op_a_hi,
    input  logic [W-1:0]      op_b_hi,
    input  logic              fmt_wide,
    input  logic [WIDE_W-1:0] exp_a,
    input  logic [WIDE_W-1:0] exp_b,
    output logic [3:0]        cond
);

    localparam int N_OPS = 2;

    fmt_e                           fmt;
    logic [N_OPS-1:0][W-1:0]        words;
    logic [N_OPS-1:0][WIDE_W-1:0]   exps_in;
    logic [N_OPS-1:0][WIDE_W-1:0]   exps_eff;
    kind_t [N_OPS-1:0]              kinds;
    cond_t                          res;
    logic                           any_special;
    logic                           both_finite;
    logic                           same_kind_special;

    assign fmt     = fmt_e'(fmt_wide);
    assign words   = {op_b_hi, op_a_hi};
    assign exps_in = {exp_b, exp_a};

    // Index 0 is operand A, index 1 is operand B.
    for (genvar i = 0; i < N_OPS; i++) begin : g_op
        dfp_xcmp_kind #(.W(W)) kind_i (
            .word_hi (words[i]),
            .fmt     (fmt),
            .kind    (kinds[i])
        );
        dfp_xcmp_exp #(.NARR_W(NARR_W), .WIDE_W(WIDE_W)) exp_i (
            .exp_in  (exps_in[i]),
            .fmt     (fmt),
            .exp_eff (exps_eff[i])
        );
    end

    always_comb begin
        any_special       = kinds[0].nan | kinds[0].inf | kinds[1].nan | kinds[1].inf;
        both_finite       = ~any_special;
        same_kind_special = (kinds[0].inf & kinds[1].inf) | (kinds[0].nan & kinds[1].nan);
        res.eq = (exps_eff[0] == exps_eff[1]) | same_kind_special;
        res.lt = both_finite & (exps_eff[0] < exps_eff[1]);
        res.gt = both_finite & (exps_eff[1] < exps_eff[0]);
        res.un = any_special & ~res.eq;
    end

    assign cond = res;

    always_comb begin
        a_r8_cond_onehot: assert ($onehot(cond))
            else $error("condition code not one-hot");
        if (cond[3] || cond[2]) begin
            a_r3_order_needs_finite: assert (!(kinds[0].nan || kinds[0].inf ||
                                               kinds[1].nan || kinds[1].inf))
                else $error("ordering reported with a special operand");
        end
        if (cond[0]) begin
            a_r6_unordered_needs_special: assert (kinds[0].nan || kinds[0].inf ||
                                                  kinds[1].nan || kinds[1].inf)
                else $error("unordered reported for two finite operands");
        end
        if (!fmt_wide && exp_a[NARR_W-1:0] == exp_b[NARR_W-1:0]) begin
            a_r7_narrow_low_bits_equal: assert (cond == 4'b0010)
                else $error("equal narrow exponents not reported equal");
        end
    end

endmodule

// File: tb/dfp_exp_compare_tb_top.sv
`timescale 1ns/1ps
module dfp_exp_compare_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a_hi = '0;
    logic [31:0] op_b_hi = '0;
    logic        fmt_wide = 1'b0;
    logic [13:0] exp_a = '0;
    logic [13:0] exp_b = '0;
    logic [3:0]  cond;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dfp_exp_compare dut_i (
        .op_a_hi  (op_a_hi),
        .op_b_hi  (op_b_hi),
        .fmt_wide (fmt_wide),
        .exp_a    (exp_a),
        .exp_b    (exp_b),
        .cond     (cond)
    );

    // Reference model built from R1, R2, R5, R6, R7.
    function automatic logic [1:0] ref_kind(logic [31:0] w, logic wide);
        logic [31:0] f;
        f = w & (wide ? 32'h7FFF_C000 : 32'h7FFC_0000);
        if (f == 32'h7C00_0000 || f == 32'h7E00_0000) return 2'b10;
        if (f == 32'h7800_0000) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [3:0] ref_cond(logic [31:0] a, logic [31:0] b, logic wide,
                                            logic [13:0] ea, logic [13:0] eb);
        logic [1:0]  ka, kb;
        logic [13:0] xa, xb;
        logic        spec, eq;
        ka   = ref_kind(a, wide);
        kb   = ref_kind(b, wide);
        xa   = wide ? ea : {4'b0, ea[9:0]};
        xb   = wide ? eb : {4'b0, eb[9:0]};
        spec = (ka != 2'b00) || (kb != 2'b00);
        eq   = (xa == xb) || (ka == 2'b01 && kb == 2'b01) || (ka == 2'b10 && kb == 2'b10);
        if (eq)   return 4'b0010;
        if (spec) return 4'b0001;
        return (xa < xb) ? 4'b1000 : 4'b0100;
    endfunction

    task automatic check(string tag, logic [3:0] expv);
        n_checks++;
        if (cond !== expv) begin
            n_errors++;
            $display("FAIL %s: a=%h b=%h wide=%0d ea=%0d eb=%0d cond actual=%b expected=%b",
                     tag, op_a_hi, op_b_hi, fmt_wide, exp_a, exp_b, cond, expv);
        end
    endtask

    task automatic apply(string tag, logic [31:0] a, logic [31:0] b, logic wide,
                         logic [13:0] ea, logic [13:0] eb);
        @(negedge clk);
        op_a_hi  = a;
        op_b_hi  = b;
        fmt_wide = wide;
        exp_a    = ea;
        exp_b    = eb;
        #2;
        check(tag, ref_cond(a, b, wide, ea, eb));
        n_checks++;
        if ($countones(cond) != 1) begin
            n_errors++;
            $display("FAIL R8: cond actual=%b expected=one-hot", cond);
        end
    endtask

    function automatic logic [31:0] rand_word(logic wide);
        logic [31:0] keep, pat, w;
        int sel;
        keep = wide ? 32'h7FFF_C000 : 32'h7FFC_0000;
        sel  = int'($urandom % 7);
        case (sel)
            0: pat = 32'h7C00_0000;
            1: pat = 32'h7E00_0000;
            2: pat = 32'h7800_0000;
            3: pat = 32'h7C00_0000 ^ (32'h1 << (14 + ($urandom % 12)));
            default: pat = $urandom & keep;
        endcase
        w = (pat & keep) | ($urandom & ~keep);
        return w;
    endfunction

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        #2;
        check("R5 reset state zero inputs", 4'b0010);
        rst = 1'b0;

        // R3 / R4: finite ordering
        apply("R3 finite below",  32'h2234_0000, 32'h2238_0000, 1'b0, 14'd5,   14'd9);
        apply("R4 finite above",  32'h2234_0000, 32'h2238_0000, 1'b0, 14'd9,   14'd5);
        apply("R3 wide below",    32'h2208_0000, 32'h0000_0000, 1'b1, 14'd100, 14'd6111);
        // R5: equality forms
        apply("R5 finite equal",  32'h2234_0000, 32'h1000_0000, 1'b0, 14'd300, 14'd300);
        apply("R5 both infinite", 32'h7800_0000, 32'hF800_0000, 1'b0, 14'd1,   14'd200);
        apply("R5 both NaN",      32'h7C00_0000, 32'h7E00_0000, 1'b1, 14'd7,   14'd900);
        apply("R5 inf vs finite same exponent", 32'h7800_0000, 32'h2234_0000, 1'b0, 14'd42, 14'd42);
        apply("R5 NaN vs inf same exponent",    32'h7E00_0000, 32'h7800_0000, 1'b1, 14'd9,  14'd9);
        // R6: unordered
        apply("R6 inf vs finite", 32'h7800_0000, 32'h2234_0000, 1'b0, 14'd10,  14'd20);
        apply("R6 NaN vs inf",    32'h7C00_0000, 32'h7800_0000, 1'b0, 14'd30,  14'd20);
        apply("R6 finite vs NaN", 32'h2234_0000, 32'h7E00_0000, 1'b1, 14'd30,  14'd20);
        // R1: mask per format, sign ignored
        apply("R1 sign ignored inf", 32'hF800_0000, 32'h2234_0000, 1'b0, 14'd3, 14'd4);
        apply("R1 narrow mask drops bit14", 32'h7C00_4000, 32'h2234_0000, 1'b0, 14'd3, 14'd4);
        apply("R1 wide mask keeps bit14",   32'h7C00_4000, 32'h2234_0000, 1'b1, 14'd3, 14'd4);
        // R2: near-special patterns are finite
        apply("R2 near NaN finite",  32'h7C04_0000, 32'h2234_0000, 1'b0, 14'd3, 14'd4);
        apply("R2 near inf finite",  32'h7A00_0000, 32'h2234_0000, 1'b1, 14'd8, 14'd4);
        // R7: exponent width per format
        apply("R7 narrow ignores high bits", 32'h2234_0000, 32'h2234_0000, 1'b0, 14'h3C05, 14'h0005);
        apply("R7 wide uses all bits",       32'h2234_0000, 32'h2234_0000, 1'b1, 14'h3C05, 14'h0005);
        apply("R7 narrow extremes",          32'h0000_0000, 32'h0000_0000, 1'b0, 14'd0,    14'd1023);

        // Random mix, checked for R3 R4 R5 R6 and R8
        for (int i = 0; i < 4000; i++) begin
            logic        w;
            logic [13:0] ea, eb;
            w  = $urandom[0];
            ea = 14'($urandom);
            eb = (($urandom % 4) == 0) ? ea : 14'($urandom);
            apply("R3 R4 R5 R6 random", rand_word(w), rand_word(w), w, ea, eb);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule